// File: doc/BRIEF.md
# Memory-Mapped Pin Port Controller

This block drives and samples a bank of 32 general-purpose pins for a processor that reaches it through a plain 32-bit register port. Software chooses each pin's direction, drives output levels and reads input levels. All of this happens inside a 4 KB window of byte addresses, and each register is 32 bits wide. Bit k of every register belongs to pin k.

Besides the full output data register, software gets two write-one aliases. One forces selected output bits high and the other forces them low, so a single pin can be changed without a read-modify-write. Incoming pin levels pass through a two-flop synchronizer and are then captured into the input data register. The bus port has no wait states: a write takes effect at the clock edge that accepts it, and read data is valid combinationally in the cycle of the request.

Top module: `pin_port_ctrl`

## Requirements
- R1: After reset the direction register reads 0xFFFFFFFF, so every pin is an input and `pin_oe` is all zero. The output data register reads 0 and `pin_out` is 0.
- R2: The direction register is at byte offset 0x134 and holds the value last written to it. A 1 in bit k makes pin k an input, with `pin_oe[k]`=0. A 0 makes pin k an output, with `pin_oe[k]`=1.
- R3: The input data register is at byte offset 0x138, and bit k reads 1 when pin k is high and 0 when it is low. A level applied to `pin_in` before a rising edge shows up in reads after the third rising edge, and not after the second.
- R4: A write to byte offset 0x13C loads the whole output data register. `pin_out` equals that register, and it reads back at 0x13C.
- R5: A write to byte offset 0x194 sets to 1 every output data bit whose written bit is 1 and leaves every other bit unchanged. Reads at 0x194 return the output data register.
- R6: A write to byte offset 0x190 clears to 0 every output data bit whose written bit is 1 and leaves every other bit unchanged. Reads at 0x190 return the output data register.
- R7: Writes to the input data register and to any offset other than 0x134, 0x13C, 0x190 and 0x194 change neither the direction register nor the output data register.
- R8: A read at any offset other than the five mapped ones returns 0. `bus_rdata` is 0 whenever no read is requested.
- R9: Registers are decoded on the word index (byte offset divided by 4), so the two low address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| pin_oe | output | 32 | Per-pin output enable to the pads, 1 = drive |
| pin_out | output | 32 | Per-pin output level |
| pin_in | input | 32 | Per-pin level from the pads, asynchronous |

## Verification
The assertions assume that `bus_sel`, `bus_wr`, `bus_addr` and `bus_wdata` are stable around the clock edge and hold no unknown values while a request is presented. The bench meets this by changing every bus input on the falling edge and returning `bus_sel` low between accesses. `pin_in` is treated as asynchronous. The assertions make no claim about it, and the bench changes it only on falling edges so that the three-edge latency it expects is exact.

// File: rtl/pio_pkg.sv
// Package: shared register word indexes and the register-select type for the
// pin port controller. Assumes a 32-bit register port and byte offsets.
package pio_pkg;

    // Word indexes (byte offset / 4) of the mapped registers.
    localparam int unsigned IX_DIR  = 32'h134 / 4;
    localparam int unsigned IX_DIN  = 32'h138 / 4;
    localparam int unsigned IX_DOUT = 32'h13C / 4;
    localparam int unsigned IX_CLR  = 32'h190 / 4;
    localparam int unsigned IX_SET  = 32'h194 / 4;

    typedef enum logic [2:0] {
        RS_NONE = 3'd0,
        RS_DIR  = 3'd1,
        RS_DIN  = 3'd2,
        RS_DOUT = 3'd3,
        RS_CLR  = 3'd4,
        RS_SET  = 3'd5
    } reg_sel_e;

    // Map a word index to the register it selects.
    function automatic reg_sel_e decode_index(input int unsigned idx);
        case (idx)
            IX_DIR:  return RS_DIR;
            IX_DIN:  return RS_DIN;
            IX_DOUT: return RS_DOUT;
            IX_CLR:  return RS_CLR;
            IX_SET:  return RS_SET;
            default: return RS_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pio_sync.sv
// Module: pio_sync
// Multi-stage flop synchronizer for a vector of asynchronous pin levels.
// Assumes each bit is independent; no cross-bit coherence is promised.
module pio_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift pin levels through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/pio_decode.sv
// Module: pio_decode
// Turns a bus request into a register select plus read and write strobes.
// Assumes byte addresses; the two low bits are not decoded.
module pio_decode
    import pio_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_sel_e          reg_sel,
    output logic              wr_en,
    output logic              rd_en
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;
    logic             unused_lo;

    assign word_idx  = bus_addr[ADDR_W-1:2];
    assign unused_lo = ^bus_addr[1:0];

    // Select the addressed register from the word index.
    always_comb begin
        reg_sel = decode_index(int'(word_idx));
    end

    assign wr_en = bus_sel &  bus_wr;
    assign rd_en = bus_sel & ~bus_wr;

endmodule

// File: rtl/pio_regs.sv
// Module: pio_regs
// Direction, output data and input capture registers with write-one
// set/clear aliases. Assumes wr_en is a single-cycle strobe qualified by
// reg_sel; the input register is read-only.
module pio_regs
    import pio_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         reg_sel,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] pins_sync,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] dout_q,
    output logic [WIDTH-1:0] din_q
);

    logic [WIDTH-1:0] dout_nxt;

    // Direction register: resets to all inputs, loaded by a full write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '1;
        end else if (wr_en && reg_sel == RS_DIR) begin
            dir_q <= wdata;
        end
    end

    // Next output data value for a full write, set alias or clear alias.
    always_comb begin
        dout_nxt = dout_q;
        if (wr_en) begin
            unique case (reg_sel)
                RS_DOUT: dout_nxt = wdata;
                RS_SET:  dout_nxt = dout_q | wdata;
                RS_CLR:  dout_nxt = dout_q & ~wdata;
                default: dout_nxt = dout_q;
            endcase
        end
    end

    // Output data register: resets to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else begin
            dout_q <= dout_nxt;
        end
    end

    // Input data register: captures the synchronized pin levels every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q <= '0;
        end else begin
            din_q <= pins_sync;
        end
    end

    // R1: state straight out of reset
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (dir_q == '1 && dout_q == '0));

    // R2: direction write lands next cycle
    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == RS_DIR) |=> dir_q == $past(wdata));

    // R5: set alias only raises written-one bits
    a_r5_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == RS_SET) |=>
            (dout_q == ($past(dout_q) | $past(wdata))));

    // R6: clear alias only lowers written-one bits
    a_r6_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == RS_CLR) |=>
            (dout_q == ($past(dout_q) & ~$past(wdata))));

    // R7: writes to read-only or unmapped offsets leave state alone
    a_r7_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (reg_sel == RS_NONE || reg_sel == RS_DIN)) |=>
            ($stable(dir_q) && $stable(dout_q)));

endmodule

// File: rtl/pio_rdmux.sv
// Module: pio_rdmux
// Read data multiplexer. Returns zero when no read is requested or the
// offset is unmapped; both aliases return the output data register.
module pio_rdmux
    import pio_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             rd_en,
    input  reg_sel_e         reg_sel,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] dout_q,
    input  logic [WIDTH-1:0] din_q,
    output logic [WIDTH-1:0] rdata
);

    // Pick the addressed register for a read, zero otherwise.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (reg_sel)
                RS_DIR:                  rdata = dir_q;
                RS_DIN:                  rdata = din_q;
                RS_DOUT, RS_SET, RS_CLR: rdata = dout_q;
                default:                 rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pin_port_ctrl.sv
// Module: pin_port_ctrl
// Top of the memory-mapped pin port controller: decode, registers,
// input synchronizer and read mux. Assumes a zero-wait-state bus whose
// inputs are stable at the clock edge; pin_in may be asynchronous.
module pin_port_ctrl
    import pio_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] pin_oe,
    output logic [DATA_W-1:0] pin_out,
    input  logic [DATA_W-1:0] pin_in
);

    reg_sel_e          reg_sel;
    logic              wr_en;
    logic              rd_en;
    logic [DATA_W-1:0] pins_sync;
    logic [DATA_W-1:0] dir_q;
    logic [DATA_W-1:0] dout_q;
    logic [DATA_W-1:0] din_q;

    pio_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .reg_sel (reg_sel),
        .wr_en   (wr_en),
        .rd_en   (rd_en)
    );

    pio_sync #(.WIDTH(DATA_W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pin_in),
        .sync_out(pins_sync)
    );

    pio_regs #(.WIDTH(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .reg_sel  (reg_sel),
        .wdata    (bus_wdata),
        .pins_sync(pins_sync),
        .dir_q    (dir_q),
        .dout_q   (dout_q),
        .din_q    (din_q)
    );

    pio_rdmux #(.WIDTH(DATA_W)) u_rdmux (
        .rd_en  (rd_en),
        .reg_sel(reg_sel),
        .dir_q  (dir_q),
        .dout_q (dout_q),
        .din_q  (din_q),
        .rdata  (bus_rdata)
    );

    // Pads drive where the direction bit is 0 (output).
    assign pin_oe  = ~dir_q;
    assign pin_out = dout_q;

    // R2: pad enable follows a direction write on the next cycle
    a_r2_oe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(IX_DIR))
            |=> pin_oe == ~$past(bus_wdata));

    // R4: full output write reaches the pins on the next cycle
    a_r4_dout_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(IX_DOUT))
            |=> pin_out == $past(bus_wdata));

endmodule

// File: tb/test_pin_port_ctrl.sv
`timescale 1ns/1ps
module test_pin_port_ctrl;

    localparam int unsigned DW = 32;
    localparam int unsigned AW = 12;
    localparam logic [AW-1:0] A_DIR  = 12'h134;
    localparam logic [AW-1:0] A_DIN  = 12'h138;
    localparam logic [AW-1:0] A_DOUT = 12'h13C;
    localparam logic [AW-1:0] A_CLR  = 12'h190;
    localparam logic [AW-1:0] A_SET  = 12'h194;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [DW-1:0] pin_oe;
    logic [DW-1:0] pin_out;
    logic [DW-1:0] pin_in = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] m_dir;
    logic [DW-1:0] m_dout;
    logic [DW-1:0] rd;

    pin_port_ctrl i_pin_port_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_oe(pin_oe), .pin_out(pin_out), .pin_in(pin_in)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Write one register; the edge between the two falling edges applies it.
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // Combinational read with no clock edge consumed.
    task automatic rdreg(input logic [AW-1:0] a, output logic [DW-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
        #1;
    endtask

    function automatic logic [DW-1:0] exp_read(input int unsigned idx);
        case (idx)
            32'h4D:               return m_dir;
            32'h4E:               return pin_in;
            32'h4F, 32'h64, 32'h65: return m_dout;
            default:              return '0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_dir = '1; m_dout = '0;

        // R1: reset state
        rdreg(A_DIR, rd);  chk("R1 dir reset", rd, 32'hFFFF_FFFF);
        chk("R1 pin_oe reset", pin_oe, '0);
        chk("R1 pin_out reset", pin_out, '0);
        rdreg(A_DOUT, rd); chk("R1 dout reset", rd, '0);

        // R2: walking output pin across all directions
        for (int k = 0; k < DW; k++) begin
            m_dir = ~(32'h1 << k);
            wr(A_DIR, m_dir);
            chk("R2 pin_oe walk", pin_oe, 32'h1 << k);
            rdreg(A_DIR, rd); chk("R2 dir readback", rd, m_dir);
        end
        m_dir = 32'hA5A5_0F0F; wr(A_DIR, m_dir);
        chk("R2 pin_oe pattern", pin_oe, ~m_dir);

        // R4: full output writes
        for (int p = 0; p < 4; p++) begin
            case (p)
                0: m_dout = 32'h1234_5678;
                1: m_dout = 32'hFFFF_FFFF;
                2: m_dout = 32'h0000_0000;
                default: m_dout = 32'hDEAD_BEEF;
            endcase
            wr(A_DOUT, m_dout);
            chk("R4 pin_out", pin_out, m_dout);
            rdreg(A_DOUT, rd); chk("R4 dout readback", rd, m_dout);
            rdreg(A_SET, rd);  chk("R5 set alias readback", rd, m_dout);
            rdreg(A_CLR, rd);  chk("R6 clr alias readback", rd, m_dout);
        end

        // R5: walking set from zero, plus a no-op set
        m_dout = '0; wr(A_DOUT, m_dout);
        for (int k = 0; k < DW; k += 3) begin
            m_dout = m_dout | (32'h1 << k);
            wr(A_SET, 32'h1 << k);
            chk("R5 set walk", pin_out, m_dout);
        end
        wr(A_SET, 32'h0); chk("R5 set zero no change", pin_out, m_dout);

        // R6: walking clear from all ones, plus a no-op clear
        m_dout = '1; wr(A_DOUT, m_dout);
        for (int k = 0; k < DW; k += 2) begin
            m_dout = m_dout & ~(32'h1 << k);
            wr(A_CLR, 32'h1 << k);
            chk("R6 clr walk", pin_out, m_dout);
        end
        wr(A_CLR, 32'h0); chk("R6 clr zero no change", pin_out, m_dout);

        // R3: input latency is three rising edges
        for (int p = 0; p < 4; p++) begin
            logic [DW-1:0] old_v;
            logic [DW-1:0] new_v;
            old_v = pin_in;
            new_v = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h8000_0001 :
                    (p == 2) ? 32'h0F0F_3C3C : 32'h0000_0000;
            @(negedge clk);
            pin_in = new_v;
            @(negedge clk); @(negedge clk);
            rdreg(A_DIN, rd); chk("R3 din before third edge", rd, old_v);
            @(negedge clk);
            rdreg(A_DIN, rd); chk("R3 din after third edge", rd, new_v);
        end
        pin_in = 32'h5A5A_C3C3;
        repeat (4) @(negedge clk);

        // R7: write all ones to every unmapped or read-only index
        for (int i = 0; i < 1024; i++) begin
            if (i != 32'h4D && i != 32'h4F && i != 32'h64 && i != 32'h65)
                wr(AW'(i * 4), 32'hFFFF_FFFF);
        end
        chk("R7 pin_out unchanged", pin_out, m_dout);
        chk("R7 pin_oe unchanged", pin_oe, ~m_dir);
        rdreg(A_DIR, rd);  chk("R7 dir unchanged", rd, m_dir);
        rdreg(A_DIN, rd);  chk("R7 din still pins", rd, pin_in);

        // R8: read sweep over the whole window
        for (int i = 0; i < 1024; i++) begin
            rdreg(AW'(i * 4), rd);
            chk("R8 read sweep", rd, exp_read(i));
        end
        bus_sel = 1'b0; bus_addr = A_DIR; #1;
        chk("R8 idle rdata zero", bus_rdata, '0);

        // R9: low address bits ignored
        m_dout = 32'h0BAD_F00D; wr(A_DOUT | 12'h3, m_dout);
        chk("R9 misaligned write", pin_out, m_dout);
        rdreg(A_DIR | 12'h1, rd); chk("R9 misaligned read", rd, m_dir);
        wr(A_SET | 12'h2, 32'hF000_0000); m_dout = m_dout | 32'hF000_0000;
        chk("R9 misaligned set", pin_out, m_dout);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule